// File: doc/BRIEF.md
# ADC sample accumulation controller

This block runs an analog-to-digital converter front-end through a sequence of conversions and adds up a programmable number of consecutive samples into one result. A small control register sets three things: the accumulation length, automatic restart, and left or right justification of the result. For each sample the block sends the converter a one-cycle start-conversion pulse. It then takes the sample over a valid/ready handshake. Every raw sample it accepts is also kept in a separate latest-sample register.

A result is offered on a valid/ready output. Software or a downstream consumer starts an accumulation with a one-cycle start strobe. Free-running operation keeps accumulations going with no further strobes. A series-mode input stops that automatic restart, so each accumulation then needs its own strobe. Back-pressure works as follows: while a result is waiting to be taken, the result value is held and no new accumulation begins. Once the consumer takes it, a free-running restart can go ahead. On the sample input, `smp_ready` is high only while the block is waiting for the sample of the conversion it just requested.

Defaults: 12-bit samples, up to 1024 samples per result, and a 24-bit result. The result width must be at least the sample width plus the largest accumulation exponent.

Top module: `adc_accum_ctrl`

## Requirements
- R1: After reset, `result_q`, `sample_q`, `res_valid`, `conv_start` and `smp_ready` are zero. All control fields are zero. A start strobe with no control write therefore produces one sample, right-adjusted.
- R2: The control field `ctrl_wdata[3:0]` holds a code N from 0 to 10. Each accumulation then takes exactly 2^N samples, and `result_q` equals their sum.
- R3: Codes 11 to 15 give a single sample per result.
- R4: With the free-run bit (`ctrl_wdata[5]`) set and series mode low, a new accumulation starts once the previous result has been taken, with no start strobe. Clearing the bit stops the restarts.
- R5: While `series_mode` is high, the free-run bit has no effect. No conversion is requested without a start strobe.
- R6: Every accepted sample handshake copies `smp_data` into `sample_q` on that clock edge. This includes the intermediate samples of an accumulation.
- R7: With the left-adjust bit (`ctrl_wdata[4]`) set, the sum is shifted left by 24-12-N bits, so the most significant bit of the 12+N-bit sum sits at bit 23. With the bit clear, the sum is zero-extended.
- R8: `result_q` and `res_valid` update together, only on the handshake of the last sample. The running sum restarts from zero for each accumulation.
- R9: The code and left-adjust setting are latched when an accumulation starts. A control write during an accumulation takes effect from the next one.
- R10: While `res_valid` is high and `res_ready` is low, `res_valid` stays high and `result_q` stays stable, and no conversion is requested.
- R11: `conv_start` is high for exactly one cycle per sample. It rises the cycle after an accepted start. `smp_ready` rises only in the cycle after `conv_start`.
- R12: A start strobe that arrives while an accumulation is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control register write enable |
| ctrl_wdata | input | 6 | [5] free-run, [4] left-adjust, [3:0] accumulation code |
| start | input | 1 | Start strobe for one accumulation |
| series_mode | input | 1 | Blocks free-running restart while high |
| conv_start | output | 1 | One-cycle start-conversion request to the converter |
| smp_valid | input | 1 | Converter sample valid |
| smp_ready | output | 1 | Block waiting for a sample |
| smp_data | input | 12 | Converter sample |
| sample_q | output | 12 | Latest accepted raw sample |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| result_q | output | 24 | Accumulated, optionally left-adjusted result |

## Verification
A start strobe that is sampled on a clock edge raises `conv_start` in the next cycle. `smp_ready` follows one cycle later and stays high until the converter stub completes the handshake. `sample_q` changes on the handshake edge. `result_q` and `res_valid` change on the edge of the final handshake. A taken result frees the block to restart on the edge after `res_ready` is seen. The bench drives every input at falling edges and reads outputs at the next falling edge after the edge on which they are due. It waits on `res_valid` rather than counting cycles, then compares sample counts, conversion pulse counts and the sum that it computes itself from the stub's sample sequence.

// File: rtl/adc_accum_pkg.sv
package adc_accum_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_t;

  // Codes above the largest supported exponent fall back to one sample.
  function automatic int eff_log2(input int code, input int max_log2);
    return (code > max_log2) ? 0 : code;
  endfunction

endpackage

// File: rtl/accum_ctrl_reg.sv
module accum_ctrl_reg #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CODE_W+1:0] wdata,
  output logic              cfg_freerun,
  output logic              cfg_leftadj,
  output logic [CODE_W-1:0] cfg_code
);
  localparam int LA_BIT = CODE_W;
  localparam int FR_BIT = CODE_W + 1;

  logic [CODE_W+1:0] ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctrl_q <= '0;
    else if (we) ctrl_q <= wdata;
  end

  always_comb begin
    cfg_freerun = ctrl_q[FR_BIT];
    cfg_leftadj = ctrl_q[LA_BIT];
    cfg_code    = ctrl_q[CODE_W-1:0];
  end

endmodule

// File: rtl/accum_seq.sv
module accum_seq
  import adc_accum_pkg::*;
#(
  parameter int CODE_W   = 4,
  parameter int MAX_LOG2 = 10
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                start,
  input  logic                                series_mode,
  input  logic                                cfg_freerun,
  input  logic [CODE_W-1:0]                   cfg_code,
  input  logic                                smp_valid,
  input  logic                                res_ready,
  output logic                                conv_start,
  output logic                                smp_ready,
  output logic                                acc_clr,
  output logic                                fin,
  output logic [$clog2(MAX_LOG2+1)-1:0]       run_log2,
  output logic                                res_valid
);
  localparam int LOG2_W = $clog2(MAX_LOG2 + 1);
  localparam int CNT_W  = (MAX_LOG2 > 0) ? MAX_LOG2 : 1;

  seq_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  last_idx;
  logic              done_once;
  logic              hs;
  logic              go;

  always_comb begin
    smp_ready  = (state == ST_WAIT);
    conv_start = (state == ST_ISSUE);
    hs         = smp_valid && smp_ready;
    last_idx   = CNT_W'((32'd1 << run_log2) - 32'd1);
    fin        = hs && (cnt == last_idx);
    go         = (state == ST_IDLE) && !res_valid &&
                 (start || (cfg_freerun && !series_mode && done_once));
    acc_clr    = go;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      run_log2  <= '0;
      done_once <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (go) begin
          run_log2 <= LOG2_W'(eff_log2(int'(cfg_code), MAX_LOG2));
          cnt      <= '0;
          state    <= ST_ISSUE;
        end
        ST_ISSUE: state <= ST_WAIT;
        ST_WAIT: begin
          if (fin) begin
            state     <= ST_IDLE;
            done_once <= 1'b1;
          end else if (hs) begin
            cnt   <= cnt + 1'b1;
            state <= ST_ISSUE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         res_valid <= 1'b0;
    else if (fin)       res_valid <= 1'b1;
    else if (res_ready) res_valid <= 1'b0;
  end

  p_one_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  p_ready_after_conv_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smp_ready) |-> $past(conv_start));
  p_hold_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> res_valid);
  p_no_conv_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !conv_start);
  p_series_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !start && series_mode) |=> !conv_start);
  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= last_idx);

endmodule

// File: rtl/accum_datapath.sv
module accum_datapath #(
  parameter int SMP_W    = 12,
  parameter int MAX_LOG2 = 10,
  parameter int RES_W    = 24
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              hs,
  input  logic [SMP_W-1:0]                  smp_data,
  input  logic                              acc_clr,
  input  logic                              fin,
  input  logic [$clog2(MAX_LOG2+1)-1:0]     run_log2,
  input  logic                              cfg_leftadj,
  output logic [SMP_W-1:0]                  sample_q,
  output logic [RES_W-1:0]                  result_q
);
  localparam int LOG2_W = $clog2(MAX_LOG2 + 1);
  localparam int ACC_W  = SMP_W + MAX_LOG2;

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] sum_next;
  logic             ladj_run;

  function automatic logic [RES_W-1:0] justify(input logic [ACC_W-1:0] s,
                                               input logic la,
                                               input logic [LOG2_W-1:0] n);
    logic [RES_W-1:0] w;
    w = RES_W'(s);
    if (la) return w << (RES_W - SMP_W - int'(n));
    return w;
  endfunction

  always_comb sum_next = acc + ACC_W'(smp_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc      <= '0;
      ladj_run <= 1'b0;
    end else if (acc_clr) begin
      acc      <= '0;
      ladj_run <= cfg_leftadj;
    end else if (hs) begin
      acc      <= sum_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  sample_q <= '0;
    else if (hs) sample_q <= smp_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   result_q <= '0;
    else if (fin) result_q <= justify(sum_next, ladj_run, run_log2);
  end

  p_sample_upd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hs |=> (sample_q == $past(smp_data)));
  p_result_only_final_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !fin |=> $stable(result_q));
  p_clear_on_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clr |=> (acc == '0));

endmodule

// File: rtl/adc_accum_ctrl.sv
module adc_accum_ctrl #(
  parameter int SMP_W    = 12,
  parameter int MAX_LOG2 = 10,
  parameter int RES_W    = 24,
  parameter int CODE_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [CODE_W+1:0] ctrl_wdata,
  input  logic              start,
  input  logic              series_mode,
  output logic              conv_start,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [SMP_W-1:0]  smp_data,
  output logic [SMP_W-1:0]  sample_q,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [RES_W-1:0]  result_q
);
  localparam int LOG2_W = $clog2(MAX_LOG2 + 1);

  logic              cfg_freerun;
  logic              cfg_leftadj;
  logic [CODE_W-1:0] cfg_code;
  logic              acc_clr;
  logic              fin;
  logic [LOG2_W-1:0] run_log2;

  accum_ctrl_reg #(.CODE_W(CODE_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .we(ctrl_we), .wdata(ctrl_wdata),
    .cfg_freerun(cfg_freerun), .cfg_leftadj(cfg_leftadj), .cfg_code(cfg_code)
  );

  accum_seq #(.CODE_W(CODE_W), .MAX_LOG2(MAX_LOG2)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .series_mode(series_mode),
    .cfg_freerun(cfg_freerun), .cfg_code(cfg_code), .smp_valid(smp_valid),
    .res_ready(res_ready), .conv_start(conv_start), .smp_ready(smp_ready),
    .acc_clr(acc_clr), .fin(fin), .run_log2(run_log2), .res_valid(res_valid)
  );

  accum_datapath #(.SMP_W(SMP_W), .MAX_LOG2(MAX_LOG2), .RES_W(RES_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .hs(smp_valid && smp_ready), .smp_data(smp_data),
    .acc_clr(acc_clr), .fin(fin), .run_log2(run_log2), .cfg_leftadj(cfg_leftadj),
    .sample_q(sample_q), .result_q(result_q)
  );

  p_valid_on_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $past(smp_valid && smp_ready));

endmodule

// File: tb/adc_accum_ctrl_tb.sv
module adc_accum_ctrl_tb;
  localparam int CLK_P = 10;
  // Vector: {left-adjust, code[3:0], expected exponent[3:0]}
  localparam int NVEC = 11;
  localparam logic [8:0] VEC [NVEC] = '{
    {1'b0, 4'd0,  4'd0}, {1'b1, 4'd0,  4'd0}, {1'b0, 4'd1,  4'd1},
    {1'b1, 4'd2,  4'd2}, {1'b0, 4'd3,  4'd3}, {1'b1, 4'd5,  4'd5},
    {1'b0, 4'd10, 4'd10}, {1'b1, 4'd10, 4'd10}, {1'b0, 4'd11, 4'd0},
    {1'b1, 4'd15, 4'd0}, {1'b0, 4'd13, 4'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctrl_we = 1'b0, start = 1'b0, series_mode = 1'b0;
  logic [5:0] ctrl_wdata = '0;
  logic smp_valid = 1'b0, res_ready = 1'b0;
  logic [11:0] smp_data = '0;
  logic conv_start, smp_ready, res_valid;
  logic [11:0] sample_q;
  logic [23:0] result_q;

  int checks = 0, errors = 0;
  int stub_idx = 0, conv_cnt = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  adc_accum_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .start(start), .series_mode(series_mode), .conv_start(conv_start),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
    .sample_q(sample_q), .res_valid(res_valid), .res_ready(res_ready),
    .result_q(result_q)
  );

  function automatic logic [11:0] sval(input int idx);
    return (idx % 5 == 0) ? 12'hFFF : 12'((idx * 2671 + 97) & 12'hFFF);
  endfunction

  function automatic longint sum_of(input int idx0, input int n);
    longint s = 0;
    for (int i = 0; i < n; i++) s += longint'(sval(idx0 + i));
    return s;
  endfunction

  function automatic longint fmt(input longint s, input bit la, input int lg);
    return la ? ((s << (12 - lg)) & 64'hFFFFFF) : s;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Converter stub: answers each conversion request one cycle later.
  initial forever begin
    @(negedge clk);
    if (conv_start) begin
      @(negedge clk);
      smp_valid = 1'b1;
      smp_data  = sval(stub_idx);
      while (!smp_ready) @(negedge clk);
      @(posedge clk);
      #1;
      smp_valid = 1'b0;
      check(sample_q == sval(stub_idx), "R6 sample register", sample_q, sval(stub_idx));
      stub_idx++;
    end
  end

  initial forever begin
    @(negedge clk);
    if (conv_start) conv_cnt++;
  end

  task automatic write_ctrl(input bit fr, input bit la, input logic [3:0] code);
    ctrl_we = 1'b1; ctrl_wdata = {fr, la, code};
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_res();
    int t = 0;
    while (!res_valid && t < 20000) begin @(negedge clk); t++; end
  endtask

  task automatic consume();
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_vec(input bit la, input logic [3:0] code, input int lg, input string req);
    int idx0, c0;
    write_ctrl(1'b0, la, code);
    idx0 = stub_idx; c0 = conv_cnt;
    pulse_start();
    wait_res();
    check(res_valid, {req, " result produced"}, res_valid, 1);
    check(stub_idx - idx0 == (1 << lg), {req, " sample count"}, stub_idx - idx0, 1 << lg);
    check(conv_cnt - c0 == (1 << lg), "R11 one request per sample", conv_cnt - c0, 1 << lg);
    check(result_q == fmt(sum_of(idx0, 1 << lg), la, lg), {req, " R7 R8 result"},
          result_q, fmt(sum_of(idx0, 1 << lg), la, lg));
    consume();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int idx0, c0;
    logic [23:0] r1;
    idle_cycles(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(result_q == 0 && sample_q == 0, "R1 data regs zero", {result_q, sample_q}, 0);
    check(!res_valid && !conv_start && !smp_ready, "R1 handshakes low",
          {res_valid, conv_start, smp_ready}, 0);
    // R1 defaults: single sample, right-adjusted; R11 request timing
    idx0 = stub_idx;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(conv_start, "R11 request the cycle after start", conv_start, 1);
    wait_res();
    check(stub_idx - idx0 == 1, "R1 default one sample", stub_idx - idx0, 1);
    check(result_q == sval(idx0), "R1 default right-adjusted", result_q, sval(idx0));
    consume();

    // Table walk: R2 counts, R3 reserved codes, R7 justification
    for (int v = 0; v < NVEC; v++) begin
      logic [8:0] e;
      e = VEC[v];
      run_vec(e[8], e[7:4], int'(e[3:0]), (e[7:4] > 4'd10) ? "R3" : "R2");
    end

    // R9 mid-run control change, R12 start ignored while busy
    write_ctrl(1'b0, 1'b0, 4'd3);
    idx0 = stub_idx; c0 = conv_cnt;
    pulse_start();
    while (stub_idx < idx0 + 2) @(negedge clk);
    write_ctrl(1'b0, 1'b1, 4'd0);
    pulse_start();
    wait_res();
    check(stub_idx - idx0 == 8, "R9 count latched", stub_idx - idx0, 8);
    check(result_q == sum_of(idx0, 8), "R9 adjust latched", result_q, sum_of(idx0, 8));
    consume();
    c0 = conv_cnt;
    idle_cycles(20);
    check(conv_cnt == c0, "R12 busy start ignored", conv_cnt - c0, 0);
    idx0 = stub_idx;
    pulse_start();
    wait_res();
    check(result_q == fmt(sval(idx0), 1'b1, 0), "R9 new setting applies next run",
          result_q, fmt(sval(idx0), 1'b1, 0));
    consume();

    // R10 back-pressure, R4 free-running restart
    write_ctrl(1'b1, 1'b0, 4'd1);
    idx0 = stub_idx;
    pulse_start();
    wait_res();
    r1 = result_q; c0 = conv_cnt;
    idle_cycles(10);
    check(res_valid && result_q == r1, "R10 result held", result_q, r1);
    check(conv_cnt == c0, "R10 no request while pending", conv_cnt - c0, 0);
    check(r1 == sum_of(idx0, 2), "R4 first run", r1, sum_of(idx0, 2));
    idx0 = stub_idx;
    consume();
    wait_res();
    check(res_valid && stub_idx - idx0 == 2, "R4 restart without strobe", stub_idx - idx0, 2);
    check(result_q == sum_of(idx0, 2), "R4 restarted sum", result_q, sum_of(idx0, 2));
    write_ctrl(1'b0, 1'b0, 4'd1);
    consume();
    c0 = conv_cnt;
    idle_cycles(20);
    check(conv_cnt == c0, "R4 stops when cleared", conv_cnt - c0, 0);

    // R5 series mode blocks free-running
    series_mode = 1'b1;
    write_ctrl(1'b1, 1'b0, 4'd0);
    c0 = conv_cnt;
    idle_cycles(20);
    check(conv_cnt == c0, "R5 no auto start", conv_cnt - c0, 0);
    idx0 = stub_idx;
    pulse_start();
    wait_res();
    check(result_q == sval(idx0), "R5 explicit start runs", result_q, sval(idx0));
    consume();
    c0 = conv_cnt;
    idle_cycles(20);
    check(conv_cnt == c0, "R5 no restart after result", conv_cnt - c0, 0);
    write_ctrl(1'b0, 1'b0, 4'd0);
    series_mode = 1'b0;
    idle_cycles(5);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule